// File: doc/BRIEF.md
# Transmit Power Ramp Sequencer

This block sets the drive level of a transmit power amplifier. It holds a small table of eight 8-bit amplifier settings and a ceiling index that is sampled when a transmission begins. When the transmit request rises, the level output walks upward through the table from entry 0 to the ceiling entry. It then stays on the ceiling entry until the request falls. After that it walks back down to entry 0, returns to zero and pulses a completion flag. Each step is held for a fixed number of clock cycles. If the request falls part-way up, the walk down starts from the entry in use at that moment.

While the level is held on the ceiling entry, an amplitude-keying mode can be selected. In that mode each data bit picks the level directly: entry 0 for a zero and entry 1 for a one. The table is loaded through a plain register-write port. A single write always lands in entry 0. A burst write fills consecutive entries from 0 upward through a pointer. That pointer goes back to 0 whenever the port is deselected.

Top module: `pa_ramp_seq`

## Requirements
- R1: After reset, `pa_level` is 0x00, `ramp_done` is 0, table entry 0 holds 0xC6 and entries 1 to 7 hold 0x00.
- R2: When `tx_en` is seen high while idle, `pa_top` is captured as the ceiling index c. From the next cycle, `pa_level` shows entries 0, 1, ..., c in order, each for STEP_LEN cycles (default 4). It then holds entry c while `tx_en` stays high.
- R3: When `tx_en` is seen low while holding, `pa_level` shows entries c, c-1, ..., 0, each for STEP_LEN cycles. The next cycle has `pa_level` = 0x00 and `ramp_done` = 1 for exactly one cycle.
- R4: With a captured ceiling of 0, no ramping occurs: `pa_level` equals entry 0 for the whole transmission and for one STEP_LEN step on the way down.
- R5: With `ook_en` = 1 while holding, `pa_level` is entry 0 when `ook_bit` = 0 and entry 1 when `ook_bit` = 1. During ramp steps `ook_bit` has no effect.
- R6: If `tx_en` falls during the ramp-up while entry i is shown, the ramp-down starts at entry i (not at the ceiling) and descends to 0.
- R7: A write with `cfg_sel` = 1, `cfg_we` = 1 and `cfg_burst` = 0 updates entry 0 only, and leaves the burst pointer unchanged.
- R8: A write with `cfg_sel` = 1, `cfg_we` = 1 and `cfg_burst` = 1 stores `cfg_wdata` in the entry named by the burst pointer and advances the pointer. After entry 7 the pointer wraps to entry 0.
- R9: Whenever `cfg_sel` is 0, the burst pointer returns to entry 0.
- R10: Changes on `pa_top` during a transmission have no effect until the next start from idle.
- R11: A high `tx_en` during the ramp-down does not interrupt it. After the completion pulse, a still-high `tx_en` starts a new ramp-up in the next cycle.
- R12: While idle, `pa_level` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_sel | input | 1 | Write port selected; low clears the burst pointer |
| cfg_we | input | 1 | Write strobe, one entry per cycle |
| cfg_burst | input | 1 | 1 = burst write at pointer, 0 = single write to entry 0 |
| cfg_wdata | input | 8 | Table data to write |
| pa_top | input | 3 | Ceiling index, captured at transmission start |
| tx_en | input | 1 | Transmit request, level sensitive |
| ook_en | input | 1 | Amplitude-keying mode while holding |
| ook_bit | input | 1 | Keying data bit |
| pa_level | output | 8 | Amplifier setting currently applied |
| ramp_done | output | 1 | One-cycle pulse when the ramp-down finishes |

## Verification
The hardest case to reach is a ramp-down that starts from an intermediate entry, because it needs `tx_en` to fall in one exact cycle of the ramp-up. The bench sweeps the release cycle over every position of a full eight-entry ramp. It then checks the whole descent from the entry in use at that moment. The table contents are visible only through the level output, so every write pattern (wrap, deselect mid-burst, single writes inside a selected window) is followed by a full-height ramp that shows all eight entries in turn.

// File: rtl/pa_ramp_pkg.sv
package pa_ramp_pkg;

    localparam int PA_DEPTH = 8;
    localparam int PA_IDX_W = $clog2(PA_DEPTH);
    localparam int PA_LVL_W = 8;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_UP   = 2'd1,
        PH_HOLD = 2'd2,
        PH_DOWN = 2'd3
    } phase_e;

    typedef struct packed {
        phase_e              ph;
        logic [PA_IDX_W-1:0] idx;
    } ramp_state_t;

    typedef struct packed {
        logic                sel;
        logic                we;
        logic                burst;
        logic [PA_LVL_W-1:0] data;
    } cfg_wr_t;

    // Entry that drives the amplifier for a given controller state.
    function automatic logic [PA_IDX_W-1:0] pick_index(
        input ramp_state_t st,
        input logic        ook_en,
        input logic        ook_bit
    );
        if (st.ph == PH_HOLD && ook_en)
            return {{(PA_IDX_W-1){1'b0}}, ook_bit};
        return st.idx;
    endfunction

    function automatic logic level_active(input phase_e ph);
        return ph != PH_IDLE;
    endfunction

endpackage

// File: rtl/pa_table.sv
module pa_table
    import pa_ramp_pkg::*;
#(
    parameter int            DEPTH      = PA_DEPTH,
    parameter int            LVL_W      = PA_LVL_W,
    parameter logic [7:0]    RST_ENTRY0 = 8'hC6
) (
    input  logic                     clk,
    input  logic                     rst,
    input  cfg_wr_t                  wr,
    input  logic [$clog2(DEPTH)-1:0] rd_idx,
    output logic [LVL_W-1:0]         rd_lvl,
    output logic [$clog2(DEPTH)-1:0] wr_ptr
);
    localparam int IW = $clog2(DEPTH);

    logic [DEPTH-1:0][LVL_W-1:0] ent;
    logic [DEPTH-1:0]            hit;
    logic                        wr_go;

    assign wr_go = wr.sel && wr.we;

    // Per-entry write decode: burst follows the pointer, single hits entry 0.
    for (genvar g = 0; g < DEPTH; g++) begin : g_hit
        assign hit[g] = wr_go && (wr.burst ? (wr_ptr == IW'(g)) : (g == 0));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < DEPTH; k++)
                ent[k] <= (k == 0) ? LVL_W'(RST_ENTRY0) : '0;
        end else begin
            for (int k = 0; k < DEPTH; k++)
                if (hit[k]) ent[k] <= wr.data[LVL_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !wr.sel)
            wr_ptr <= '0;
        else if (wr_go && wr.burst)
            wr_ptr <= wr_ptr + IW'(1);
    end

    assign rd_lvl = ent[rd_idx];

endmodule

// File: rtl/pa_ramp_ctrl.sv
module pa_ramp_ctrl
    import pa_ramp_pkg::*;
#(
    parameter int STEP_LEN = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tx_en,
    input  logic [PA_IDX_W-1:0] pa_top,
    output ramp_state_t         st,
    output logic                done
);
    localparam int CNT_W = (STEP_LEN > 1) ? $clog2(STEP_LEN) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STEP_LEN - 1);

    logic [CNT_W-1:0]    cnt;
    logic [PA_IDX_W-1:0] top_q;
    logic                step_end;

    assign step_end = (cnt == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            st.ph  <= PH_IDLE;
            st.idx <= '0;
            cnt    <= '0;
            top_q  <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (st.ph)
                PH_IDLE: begin
                    if (tx_en) begin
                        top_q  <= pa_top;
                        st.idx <= '0;
                        cnt    <= '0;
                        st.ph  <= (pa_top == '0) ? PH_HOLD : PH_UP;
                    end
                end
                PH_UP: begin
                    if (!tx_en) begin
                        st.ph <= PH_DOWN;
                        cnt   <= '0;
                    end else if (step_end) begin
                        cnt <= '0;
                        if (st.idx == top_q) st.ph  <= PH_HOLD;
                        else                 st.idx <= st.idx + PA_IDX_W'(1);
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                PH_HOLD: begin
                    if (!tx_en) begin
                        st.ph <= PH_DOWN;
                        cnt   <= '0;
                    end
                end
                PH_DOWN: begin
                    if (step_end) begin
                        cnt <= '0;
                        if (st.idx == '0) begin
                            st.ph <= PH_IDLE;
                            done  <= 1'b1;
                        end else begin
                            st.idx <= st.idx - PA_IDX_W'(1);
                        end
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                default: st.ph <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pa_level_mux.sv
module pa_level_mux
    import pa_ramp_pkg::*;
#(
    parameter int LVL_W = PA_LVL_W
) (
    input  ramp_state_t         st,
    input  logic                ook_en,
    input  logic                ook_bit,
    input  logic [LVL_W-1:0]    tab_lvl,
    output logic [PA_IDX_W-1:0] tab_idx,
    output logic [LVL_W-1:0]    level
);
    always_comb begin
        tab_idx = pick_index(st, ook_en, ook_bit);
        level   = level_active(st.ph) ? tab_lvl : '0;
    end

endmodule

// File: rtl/pa_ramp_seq.sv
module pa_ramp_seq
    import pa_ramp_pkg::*;
#(
    parameter int         STEP_LEN   = 4,
    parameter logic [7:0] RST_ENTRY0 = 8'hC6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_sel,
    input  logic                cfg_we,
    input  logic                cfg_burst,
    input  logic [PA_LVL_W-1:0] cfg_wdata,
    input  logic [PA_IDX_W-1:0] pa_top,
    input  logic                tx_en,
    input  logic                ook_en,
    input  logic                ook_bit,
    output logic [PA_LVL_W-1:0] pa_level,
    output logic                ramp_done
);
    cfg_wr_t             wr_req;
    ramp_state_t         ramp_st;
    logic [PA_IDX_W-1:0] rd_idx;
    logic [PA_LVL_W-1:0] rd_lvl;
    logic [PA_IDX_W-1:0] wr_ptr;

    assign wr_req = '{sel: cfg_sel, we: cfg_we, burst: cfg_burst, data: cfg_wdata};

    pa_table #(
        .DEPTH      (PA_DEPTH),
        .LVL_W      (PA_LVL_W),
        .RST_ENTRY0 (RST_ENTRY0)
    ) u_table (
        .clk    (clk),
        .rst    (rst),
        .wr     (wr_req),
        .rd_idx (rd_idx),
        .rd_lvl (rd_lvl),
        .wr_ptr (wr_ptr)
    );

    pa_ramp_ctrl #(
        .STEP_LEN (STEP_LEN)
    ) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .tx_en  (tx_en),
        .pa_top (pa_top),
        .st     (ramp_st),
        .done   (ramp_done)
    );

    pa_level_mux #(
        .LVL_W (PA_LVL_W)
    ) u_mux (
        .st      (ramp_st),
        .ook_en  (ook_en),
        .ook_bit (ook_bit),
        .tab_lvl (rd_lvl),
        .tab_idx (rd_idx),
        .level   (pa_level)
    );

endmodule

// File: rtl/pa_ramp_seq_chk.sv
module pa_ramp_seq_chk
    import pa_ramp_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                tx_en,
    input logic                cfg_sel,
    input logic                cfg_we,
    input logic                cfg_burst,
    input logic [PA_LVL_W-1:0] pa_level,
    input logic                ramp_done,
    input ramp_state_t         ramp_st,
    input logic [PA_IDX_W-1:0] wr_ptr
);
    assert_done_single_R3: assert property (@(posedge clk) disable iff (rst)
        ramp_done |=> !ramp_done);

    assert_done_at_idle_R3: assert property (@(posedge clk) disable iff (rst)
        ramp_done |-> (ramp_st.ph == PH_IDLE && pa_level == '0));

    assert_idle_zero_R12: assert property (@(posedge clk) disable iff (rst)
        (ramp_st.ph == PH_IDLE) |-> (pa_level == '0));

    assert_up_ascends_R2: assert property (@(posedge clk) disable iff (rst)
        (ramp_st.ph == PH_UP && $past(ramp_st.ph) == PH_UP) |->
        (ramp_st.idx == $past(ramp_st.idx) ||
         ramp_st.idx == PA_IDX_W'($past(ramp_st.idx) + 1)));

    assert_down_descends_R3: assert property (@(posedge clk) disable iff (rst)
        (ramp_st.ph == PH_DOWN && $past(ramp_st.ph) == PH_DOWN) |->
        (ramp_st.idx == $past(ramp_st.idx) ||
         ramp_st.idx == PA_IDX_W'($past(ramp_st.idx) - 1)));

    assert_abort_keeps_entry_R6: assert property (@(posedge clk) disable iff (rst)
        (ramp_st.ph == PH_DOWN && $past(ramp_st.ph) == PH_UP) |->
        (ramp_st.idx == $past(ramp_st.idx)));

    assert_down_not_interrupted_R11: assert property (@(posedge clk) disable iff (rst)
        (ramp_st.ph == PH_DOWN && tx_en) |=>
        (ramp_st.ph == PH_DOWN || ramp_st.ph == PH_IDLE));

    assert_ptr_clear_R9: assert property (@(posedge clk) disable iff (rst)
        !cfg_sel |=> (wr_ptr == '0));

    assert_burst_advance_R8: assert property (@(posedge clk) disable iff (rst)
        (cfg_sel && cfg_we && cfg_burst) |=>
        (wr_ptr == PA_IDX_W'($past(wr_ptr) + 1)));

    assert_single_keeps_ptr_R7: assert property (@(posedge clk) disable iff (rst)
        (cfg_sel && !(cfg_we && cfg_burst)) |=> $stable(wr_ptr));

endmodule

bind pa_ramp_seq pa_ramp_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .tx_en     (tx_en),
    .cfg_sel   (cfg_sel),
    .cfg_we    (cfg_we),
    .cfg_burst (cfg_burst),
    .pa_level  (pa_level),
    .ramp_done (ramp_done),
    .ramp_st   (ramp_st),
    .wr_ptr    (wr_ptr)
);

// File: tb/pa_ramp_seq_tb.sv
module pa_ramp_seq_tb;
    localparam int S = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_sel = 1'b0, cfg_we = 1'b0, cfg_burst = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [2:0] pa_top = '0;
    logic       tx_en = 1'b0, ook_en = 1'b0, ook_bit = 1'b0;
    logic [7:0] pa_level;
    logic       ramp_done;

    int n_vec = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit fin   = 1'b0;

    logic [7:0] tab [8];

    always #5 clk = ~clk;

    pa_ramp_seq #(.STEP_LEN(S), .RST_ENTRY0(8'hC6)) u_dut (
        .clk(clk), .rst(rst), .cfg_sel(cfg_sel), .cfg_we(cfg_we),
        .cfg_burst(cfg_burst), .cfg_wdata(cfg_wdata), .pa_top(pa_top),
        .tx_en(tx_en), .ook_en(ook_en), .ook_bit(ook_bit),
        .pa_level(pa_level), .ramp_done(ramp_done)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !fin) begin
            fin = 1'b1;
            n_bad++;
            $display("FAIL watchdog: got %0d cycles expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic burst(input int n, input logic [7:0] base);
        int p = 0;
        cfg_sel = 1'b1; cfg_burst = 1'b1;
        for (int k = 0; k < n; k++) begin
            cfg_we = 1'b1;
            cfg_wdata = 8'(base + k);
            tab[p] = 8'(base + k);
            p = (p + 1) % 8;
            step();
        end
        cfg_we = 1'b0; cfg_sel = 1'b0; cfg_burst = 1'b0;
        step();
    endtask

    task automatic single(input logic [7:0] d);
        cfg_sel = 1'b1; cfg_burst = 1'b0; cfg_we = 1'b1; cfg_wdata = d;
        tab[0] = d;
        step();
        cfg_we = 1'b0; cfg_sel = 1'b0;
        step();
    endtask

    // Descent from entry i, then the completion pulse, then idle.
    task automatic down_check(input int i, input string tag);
        for (int c = 0; c < (i + 1) * S; c++) begin
            step();
            chk({tag, " down level"}, pa_level, tab[i - c / S]);
            chk({tag, " no early done"}, {7'd0, ramp_done}, 8'd0);
        end
        step();
        chk({tag, " R3 idle level"}, pa_level, 8'h00);
        chk({tag, " R3 done pulse"}, {7'd0, ramp_done}, 8'd1);
        step();
        chk({tag, " R3 done single"}, {7'd0, ramp_done}, 8'd0);
        chk({tag, " R12 idle zero"}, pa_level, 8'h00);
    endtask

    task automatic run_ramp(input int top, input int hold, input string tag);
        pa_top = 3'(top);
        tx_en  = 1'b1;
        for (int c = 0; c < (top + 1) * S; c++) begin
            step();
            chk({tag, " R2 up level"}, pa_level, tab[c / S]);
        end
        for (int h = 0; h < hold; h++) begin
            step();
            chk({tag, " R2 hold level"}, pa_level, tab[top]);
        end
        tx_en = 1'b0;
        down_check(top, tag);
    endtask

    initial begin
        tab[0] = 8'hC6;
        for (int k = 1; k < 8; k++) tab[k] = 8'h00;

        repeat (3) step();
        rst = 1'b0;
        step();
        chk("R1 reset level", pa_level, 8'h00);
        chk("R1 reset done", {7'd0, ramp_done}, 8'd0);
        chk("R12 idle level", pa_level, 8'h00);
        run_ramp(7, 3, "R1 reset table");

        // R2 R3 R4: full sweep of the ceiling index
        burst(8, 8'h11);
        for (int k = 0; k < 8; k++) tab[k] = 8'(8'h11 + k);
        for (int t = 0; t < 8; t++)
            run_ramp(t, 2 + t, (t == 0) ? "R4 top zero" : "R2 R3 sweep");

        // R8: pointer wraps after entry 7
        burst(10, 8'hA0);
        run_ramp(7, 2, "R8 burst wrap");

        // R9: deselect returns pointer to entry 0
        burst(3, 8'hB0);
        burst(2, 8'hC0);
        run_ramp(7, 2, "R9 ptr clear");

        // R7: single writes land in entry 0 only
        single(8'h5A);
        cfg_sel = 1'b1; cfg_burst = 1'b0; cfg_we = 1'b1;
        cfg_wdata = 8'h3C; step();
        cfg_wdata = 8'h7E; step();
        tab[0] = 8'h7E;
        cfg_we = 1'b0; cfg_sel = 1'b0; step();
        run_ramp(7, 2, "R7 single write");

        // R6: release tx_en at each cycle of the ramp-up
        burst(8, 8'h20);
        for (int k = 0; k < 8; k++) tab[k] = 8'(8'h20 + k);
        for (int m = 1; m < 8 * S; m++) begin
            pa_top = 3'd7;
            tx_en  = 1'b1;
            for (int c = 0; c < m; c++) begin
                step();
                chk("R6 partial up", pa_level, tab[c / S]);
            end
            tx_en = 1'b0;
            down_check((m - 1) / S, "R6 abort");
        end

        // R10: ceiling change mid-transmission ignored
        pa_top = 3'd2;
        tx_en  = 1'b1;
        for (int c = 0; c < 3 * S; c++) begin
            step();
            if (c == 2) pa_top = 3'd7;
            chk("R10 up", pa_level, tab[c / S]);
        end
        for (int h = 0; h < 5; h++) begin
            step();
            chk("R10 hold ignores top", pa_level, tab[2]);
        end
        tx_en = 1'b0;
        down_check(2, "R10 down");

        // R5: keying selects entry 0 or 1 while holding only
        ook_en = 1'b1; ook_bit = 1'b1; pa_top = 3'd1; tx_en = 1'b1;
        for (int c = 0; c < 2 * S; c++) begin
            step();
            chk("R5 up ignores bit", pa_level, tab[c / S]);
        end
        for (int k = 0; k < 16; k++) begin
            ook_bit = k[0] ^ k[2];
            step();
            chk("R5 keyed level", pa_level, tab[{2'b00, ook_bit}]);
        end
        ook_bit = 1'b0; ook_en = 1'b0; tx_en = 1'b0;
        down_check(1, "R5 down");

        // R11: tx_en during ramp-down does not interrupt it
        run_ramp(3, 0, "R11 prep");
        pa_top = 3'd3; tx_en = 1'b1;
        for (int c = 0; c < 4 * S; c++) step();
        for (int h = 0; h < 2; h++) begin
            step();
            chk("R11 hold", pa_level, tab[3]);
        end
        tx_en = 1'b0;
        for (int c = 0; c < 4 * S; c++) begin
            if (c == 2) tx_en = 1'b1;
            step();
            chk("R11 down continues", pa_level, tab[3 - c / S]);
        end
        step();
        chk("R11 done level", pa_level, 8'h00);
        chk("R11 done pulse", {7'd0, ramp_done}, 8'd1);
        pa_top = 3'd0;
        step();
        chk("R11 restart", pa_level, tab[0]);
        tx_en = 1'b0;
        down_check(0, "R11 restart");

        fin = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule